// File: doc/BRIEF.md
# Dual-Mapped Microcontroller Data Memory

This block is the data-memory subsystem of an 8-bit microcontroller core. The core presents one request per cycle, tagged with an addressing mode. The block resolves it to one of three places: a 256-byte internal RAM, a 1 KB external data RAM, or a special-function-register (SFR) port.

The upper half of the internal address range is dual-mapped. An indirect access there reaches RAM. A direct access with the same address goes out on the SFR port and leaves the RAM alone. The lowest 32 bytes hold four banks of eight working registers, and the bank is chosen by a 2-bit input. Sixteen bytes starting at 0x20 can also be reached one bit at a time. A bit write is a read-modify-write of the containing byte, done in a single cycle. The external RAM answers the whole 16-bit external space and repeats every 1 KB.

Read data comes back one clock after the request, qualified by a valid strobe.

Top module: `dmem_dualmap`

## Requirements
- R1: A direct access (mode 0) or an indirect access (mode 1) with an address in 0x00–0x7F reaches the same internal RAM byte.
- R2: An indirect access (mode 1) with an address in 0x80–0xFF reads or writes the upper 128 bytes of internal RAM.
- R3: A direct access (mode 0) with an address in 0x80–0xFF never writes the internal RAM. The address goes out on sfr_addr, a write raises sfr_we with the data on sfr_wdata, and a read raises sfr_re and returns sfr_rdata.
- R4: A register access (mode 2) reaches internal byte bank_sel×8 + addr[2:0].
- R5: A bit read (mode 3) with a bit address b below 0x80 returns bit (b mod 8) of internal byte 0x20 + (b div 8) on rd_data[0], with rd_data[7:1] zero.
- R6: A bit write (mode 3, b below 0x80) sets the addressed bit to req_wdata[0] and leaves the other seven bits of that byte unchanged.
- R7: A bit access with b in 0x80–0xFF is forwarded to the SFR port. sfr_addr carries b unchanged, sfr_bit is 1 and sfr_wdata carries req_wdata. A read returns the full sfr_rdata byte.
- R8: An external access (mode 4) uses only addr[9:0], so the 1024-byte RAM repeats every 0x400 across 0x0000–0xFFFF.
- R9: A read in modes 0–4 raises rd_valid with its data exactly one clock later. Writes and idle cycles give rd_valid 0. After reset rd_valid and rd_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel | input | 2 | Working-register bank for mode 2 |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | 0 direct, 1 indirect, 2 register, 3 bit, 4 external |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | 16 | Byte, register, bit or external address |
| req_wdata | input | 8 | Write data (bit 0 for bit writes) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| sfr_addr | output | 8 | SFR or SFR-bit address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_we | output | 1 | SFR write strobe |
| sfr_re | output | 1 | SFR read strobe |
| sfr_bit | output | 1 | SFR access is a bit access |
| sfr_rdata | input | 8 | SFR read data, same cycle as sfr_re |

## Verification
Four properties are checked on every cycle:
- a direct access to the upper range never writes internal RAM;
- a bit write changes at most one bit of its byte;
- the SFR strobes are never raised together;
- read responses keep their one-cycle timing.

Only the bench's scenarios can show where each access lands and what value it returns. Examples are bank-relative register addresses, the same cell reached through two modes, the 1 KB wrap of the external space, and the upper RAM keeping its value while the SFR path takes direct writes at the same addresses.

// File: rtl/dmem_dualmap.sv
module dmem_dualmap #(
  parameter int XAW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bank_sel,
  input  logic        req_valid,
  input  logic [2:0]  req_mode,
  input  logic        req_we,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic [7:0]  sfr_addr,
  output logic [7:0]  sfr_wdata,
  output logic        sfr_we,
  output logic        sfr_re,
  output logic        sfr_bit,
  input  logic [7:0]  sfr_rdata
);
  localparam int XDEPTH = 1 << XAW;
  localparam logic [2:0] MD_DIR = 3'd0, MD_IND = 3'd1, MD_REG = 3'd2,
                         MD_BIT = 3'd3, MD_EXT = 3'd4;
  localparam logic [3:0] BIT_BASE_HI = 4'h2;

  logic [7:0] iram [256];
  logic [7:0] xram [XDEPTH];

  logic       to_iram, to_xram, to_sfr, is_bit;
  logic [7:0] iidx;
  logic [2:0] bpos;

  always_comb begin
    to_iram = 1'b0;
    to_xram = 1'b0;
    to_sfr  = 1'b0;
    is_bit  = 1'b0;
    iidx    = req_addr[7:0];
    bpos    = req_addr[2:0];
    case (req_mode)
      MD_DIR: begin to_sfr = req_addr[7]; to_iram = !req_addr[7]; end
      MD_IND: to_iram = 1'b1;
      MD_REG: begin to_iram = 1'b1; iidx = {3'b000, bank_sel, req_addr[2:0]}; end
      MD_BIT: begin
        is_bit  = 1'b1;
        to_sfr  = req_addr[7];
        to_iram = !req_addr[7];
        iidx    = {BIT_BASE_HI, req_addr[6:3]};
      end
      MD_EXT: to_xram = 1'b1;
      default: ;
    endcase
  end

  wire [XAW-1:0] xidx  = req_addr[XAW-1:0];
  wire [7:0]     ibyte = iram[iidx];
  wire [7:0]     xbyte = xram[xidx];
  wire [7:0]     bmask = 8'h01 << bpos;
  wire [7:0]     iwr   = is_bit ? ((ibyte & ~bmask) | (req_wdata[0] ? bmask : 8'h00))
                                : req_wdata;
  wire           iram_we = req_valid && req_we && to_iram;
  wire           xram_we = req_valid && req_we && to_xram;
  wire           rd_req  = req_valid && !req_we && (to_iram || to_xram || to_sfr);
  wire           unused_hi = ^req_addr[15:XAW];

  assign sfr_addr  = req_addr[7:0];
  assign sfr_wdata = req_wdata;
  assign sfr_we    = req_valid && req_we && to_sfr;
  assign sfr_re    = req_valid && !req_we && to_sfr;
  assign sfr_bit   = req_valid && to_sfr && is_bit;

  always_ff @(posedge clk) begin
    if (iram_we) iram[iidx] <= iwr;
    if (xram_we) xram[xidx] <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_req;
      if (rd_req)
        rd_data <= to_sfr  ? sfr_rdata :
                   to_xram ? xbyte :
                   is_bit  ? {7'b0, ibyte[bpos]} : ibyte;
      else
        rd_data <= 8'h00;
    end
  end

  // R3: upper direct range never lands in internal RAM
  a_r3_dir_hi_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == MD_DIR && req_addr[7]) |-> !iram_we);

  // R3: SFR read and write strobes are exclusive
  a_r3_sfr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_we && sfr_re));

  // R6: bit write alters at most one bit of its byte
  a_r6_bit_rmw: assert property (@(posedge clk) disable iff (!rst_n)
    (iram_we && is_bit) |=> $countones(iram[$past(iidx)] ^ $past(ibyte)) <= 1);

  // R9: read answered one clock later
  a_r9_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && req_mode <= MD_EXT) |=> rd_valid);

  // R9: writes give no read response
  a_r9_no_rd_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> !rd_valid);
endmodule

// File: tb/dmem_dualmap_tb.sv
module dmem_dualmap_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  bank_sel = 2'd0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [2:0]  req_mode = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        rd_valid, sfr_we, sfr_re, sfr_bit;
  logic [7:0]  rd_data, sfr_addr, sfr_wdata, sfr_rdata;

  assign sfr_rdata = sfr_addr ^ 8'hA5;

  dmem_dualmap dut_i (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .req_valid(req_valid),
    .req_mode(req_mode), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
    .sfr_re(sfr_re), .sfr_bit(sfr_bit), .sfr_rdata(sfr_rdata));

  always #2 clk = ~clk;

  int unsigned n_cmp = 0, n_bad = 0;
  int m_iram [256];
  int m_xram [1024];
  logic       exp_rv = 1'b0;
  logic [7:0] exp_rd = 8'h00;
  string      exp_tag = "R9";
  bit         done = 1'b0;

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_rd();
    check(exp_tag, "rd_valid", rd_valid, exp_rv);
    if (exp_rv) check(exp_tag, "rd_data", rd_data, exp_rd);
  endtask

  task automatic do_op(string tag, bit v, int mode, bit we, int addr, int wd, int bank);
    int  idx, b;
    bit  sfr, xr, bitop;
    @(negedge clk);
    check_rd();
    req_valid = v; req_mode = 3'(mode); req_we = we;
    req_addr = 16'(addr); req_wdata = 8'(wd); bank_sel = 2'(bank);
    sfr = 0; xr = 0; bitop = 0; idx = addr & 8'hFF; b = addr & 7;
    case (mode)
      0: sfr = (addr & 8'h80) != 0;
      2: idx = bank * 8 + (addr & 7);
      3: begin bitop = 1; sfr = (addr & 8'h80) != 0; idx = 32 + ((addr & 8'h7F) >> 3); end
      4: xr = 1;
      default: ;
    endcase
    #1;
    check(tag, "sfr_we", sfr_we, v && we && sfr);
    check(tag, "sfr_re", sfr_re, v && !we && sfr);
    check(tag, "sfr_bit", sfr_bit, v && sfr && bitop);
    if (v && sfr) begin
      check(tag, "sfr_addr", sfr_addr, addr & 8'hFF);
      if (we) check(tag, "sfr_wdata", sfr_wdata, wd & 8'hFF);
    end
    exp_tag = tag;
    exp_rv  = v && !we && mode <= 4;
    exp_rd  = 8'h00;
    if (exp_rv) begin
      if (sfr)        exp_rd = 8'((addr & 8'hFF) ^ 8'hA5);
      else if (xr)    exp_rd = 8'(m_xram[addr % 1024]);
      else if (bitop) exp_rd = 8'((m_iram[idx] >> b) & 1);
      else            exp_rd = 8'(m_iram[idx]);
    end
    if (v && we && mode <= 4 && !sfr) begin
      if (xr) m_xram[addr % 1024] = wd & 8'hFF;
      else if (bitop) m_iram[idx] = (m_iram[idx] & ~(1 << b)) | ((wd & 1) << b);
      else m_iram[idx] = wd & 8'hFF;
    end
  endtask

  function automatic string mtag(int mode, int addr);
    case (mode)
      0: return (addr & 8'h80) != 0 ? "R3" : "R1";
      1: return (addr & 8'h80) != 0 ? "R2" : "R1";
      2: return "R4";
      3: return (addr & 8'h80) != 0 ? "R7" : "R6";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #9;
    check("R9", "reset rd_valid", rd_valid, 0);
    check("R9", "reset rd_data", rd_data, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) do_op("R2", 1, 1, 1, i, (i * 7 + 3) & 255, 0);
    for (int i = 0; i < 1024; i++) do_op("R8", 1, 4, 1, i, (i * 13 + 1) & 255, 0);
    // directed corners
    do_op("R8", 1, 4, 1, 16'h0013, 8'h5C, 0);
    do_op("R8", 1, 4, 0, 16'h0413, 0, 0);
    do_op("R8", 1, 4, 0, 16'hFC13, 0, 0);
    do_op("R3", 1, 0, 1, 8'h85, 8'h77, 0);
    do_op("R2", 1, 1, 0, 8'h85, 0, 0);
    do_op("R3", 1, 0, 0, 8'h85, 0, 0);
    do_op("R4", 1, 2, 1, 5, 8'hC3, 2);
    do_op("R4", 1, 1, 0, 8'h15, 0, 0);
    do_op("R4", 1, 2, 0, 5, 0, 3);
    do_op("R1", 1, 0, 1, 8'h40, 8'h9E, 0);
    do_op("R1", 1, 1, 0, 8'h40, 0, 0);
    do_op("R6", 1, 1, 1, 8'h21, 8'h00, 0);
    do_op("R6", 1, 3, 1, 8'h0B, 8'hFF, 0);
    do_op("R6", 1, 1, 0, 8'h21, 0, 0);
    do_op("R5", 1, 3, 0, 8'h0B, 0, 0);
    do_op("R5", 1, 3, 0, 8'h0A, 0, 0);
    do_op("R6", 1, 3, 1, 8'h7F, 8'h00, 0);
    do_op("R6", 1, 1, 0, 8'h2F, 0, 0);
    do_op("R7", 1, 3, 1, 8'hE3, 8'h01, 0);
    do_op("R7", 1, 3, 0, 8'hE3, 0, 0);
    do_op("R9", 0, 0, 0, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int md, ad;
      md = $urandom % 5;
      ad = $urandom % 65536;
      do_op(mtag(md, ad), ($urandom % 8) != 0, md, $urandom % 2, ad,
            $urandom % 256, $urandom % 4);
    end
    do_op("R9", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_rd();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule